// File: doc/BRIEF.md
# Packet Receive Buffer with Per-Packet Length Queue

This block sits at the receive end of a 32-bit streaming link. It accepts beats with a valid/ready handshake and an end-of-packet marker, and writes every data word into a word store. When the final beat of a packet is accepted, the packet's word count and its destination tag go into a separate queue, one entry per packet. Software drains the buffer through a small register read port.

The software loop for each packet is fixed. It reads the occupancy register. If that value is nonzero, it reads the length register, which claims the oldest complete packet. It then reads the destination register, and then reads the data register once per word. The loop repeats until occupancy reads zero. A length read takes exactly one packet from the queue, so packets that arrive back to back are never merged into one length. After the claim, occupancy covers only the words of packets that are still unclaimed. An interrupt flag reports that a packet has arrived. It stays set until software writes 1 to clear it.

Top module: `pkt_rx_fifo`

## Requirements
- R1: The occupancy register (address 0) reports, in 32-bit words, the total size of all complete packets whose length has not yet been claimed. Words of a packet whose last beat has not arrived are not counted. It reads 0 after reset.
- R2: A read of the length register (address 1) returns the byte count of the oldest complete unclaimed packet, equal to 4 times its word count, and claims that packet. It never returns a sum over several packets.
- R3: After a claim, occupancy drops by the claimed packet's word count. It reads 0 if no other complete packet is buffered, and nonzero if another one is.
- R4: The destination register (address 2) returns the `s_tdest` value sampled on the last beat of the most recently claimed packet.
- R5: Each read of the data register (address 3) returns the next word of the claimed packets in arrival order and removes it. A data read when no claimed words remain returns 0 and removes nothing.
- R6: A length read when no complete packet is pending returns 0 and changes no state: occupancy is unchanged and the next packet can still be claimed.
- R7: `s_tready` is low while the word store holds DATA_DEPTH words, or while the length queue holds MAX_PKTS entries. It returns high once software frees space.
- R8: `irq` goes high on the cycle after a last beat is accepted. It stays high until a write with bit 0 set reaches the interrupt register (address 4). A write with bit 0 clear does not clear it. A read of that register returns the flag in bit 0.
- R9: For every read request, `reg_rvalid` is high with the result on `reg_rdata` in the following cycle. Unmapped addresses (5 to 7) read 0.
- R10: After reset `s_tready` is high and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| s_tvalid | input | 1 | Stream beat valid |
| s_tready | output | 1 | Stream beat accepted when high together with valid |
| s_tdata | input | 32 | Stream data word |
| s_tlast | input | 1 | Final beat of a packet |
| s_tdest | input | DEST_W | Destination tag, sampled on the final beat |
| reg_req | input | 1 | Register access request, one cycle |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read result valid, one cycle after a read request |
| irq | output | 1 | Packet-received flag |

## Verification
The bench sends two packets back to back before any claim. It then checks that the first length read returns only the first packet's bytes and that occupancy stays nonzero afterwards. A design that summed lengths, or that cleared occupancy on every claim, would fail here. The bench also reads occupancy while a packet is only partly received, where a design that counted words on arrival would report them early. It reads length on an empty queue to catch a spurious pop, and it reads the data register with nothing claimed to catch a read past the claimed words. It fills the length queue and the word store separately to show that each one alone stalls the stream and that draining releases it. Finally it writes 0 and then 1 to the interrupt register, to catch a flag that clears on any write.

// File: rtl/pkt_rx_pkg.sv
package pkt_rx_pkg;

  localparam int WORD_W         = 32;
  localparam int BYTES_PER_WORD = 4;

  typedef enum logic [2:0] {
    REG_OCC  = 3'd0,
    REG_LEN  = 3'd1,
    REG_DEST = 3'd2,
    REG_DATA = 3'd3,
    REG_IRQ  = 3'd4
  } reg_sel_e;

endpackage

// File: rtl/prf_sync_fifo.sv
module prf_sync_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d;
  logic [AW-1:0] rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign full  = (cnt_q == FULL_CNT);
  assign empty = (cnt_q == '0);
  assign head  = mem[rd_ptr_q];

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (push) wr_ptr_d = (wr_ptr_q == LAST_IDX) ? '0 : wr_ptr_q + 1'b1;
    if (pop)  rd_ptr_d = (rd_ptr_q == LAST_IDX) ? '0 : rd_ptr_q + 1'b1;
    if (push && !pop)      cnt_d = cnt_q + 1'b1;
    else if (pop && !push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (push || pop) begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr_q] <= din;
  end

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!full || pop));

  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/prf_ingress.sv
module prf_ingress #(
  parameter int DEST_W = 4,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_tvalid,
  input  logic              s_tlast,
  input  logic [DEST_W-1:0] s_tdest,
  input  logic              data_full,
  input  logic              lenq_full,
  output logic              s_tready,
  output logic              beat_acc,
  output logic              pkt_done,
  output logic [CNT_W-1:0]  pkt_words,
  output logic [DEST_W-1:0] pkt_dest
);

  logic [CNT_W-1:0] cur_words_q, cur_words_d;

  assign s_tready  = !data_full && !lenq_full;
  assign beat_acc  = s_tvalid && s_tready;
  assign pkt_done  = beat_acc && s_tlast;
  assign pkt_words = cur_words_q + 1'b1;
  assign pkt_dest  = s_tdest;

  always_comb begin
    cur_words_d = cur_words_q;
    if (beat_acc) cur_words_d = s_tlast ? '0 : cur_words_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cur_words_q <= '0;
    else if (beat_acc) cur_words_q <= cur_words_d;
  end

  assert_partial_fits_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cur_words_q < CNT_W'(DEPTH));

endmodule

// File: rtl/prf_regs.sv
module prf_regs
  import pkt_rx_pkg::*;
#(
  parameter int DEST_W = 4,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_req,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              reg_rvalid,
  output logic              irq,
  input  logic              pkt_done,
  input  logic [CNT_W-1:0]  pkt_words,
  input  logic              lenq_empty,
  input  logic [CNT_W-1:0]  lenq_words,
  input  logic [DEST_W-1:0] lenq_dest,
  output logic              claim,
  input  logic              data_empty,
  input  logic [WORD_W-1:0] data_head,
  output logic              data_pop
);

  logic [CNT_W-1:0]  occ_q, occ_d;
  logic [CNT_W-1:0]  left_q, left_d;
  logic [DEST_W-1:0] dest_q;
  logic              irq_q, irq_d;
  logic [WORD_W-1:0] rdata_q, rdata_d;
  logic              rvalid_q;
  logic              rd_req, irq_clr;
  logic [CNT_W-1:0]  add_words, sub_words;
  logic              unused_wdata;

  assign unused_wdata = ^reg_wdata[WORD_W-1:1];

  assign rd_req   = reg_req && !reg_we;
  assign claim    = rd_req && (reg_addr == REG_LEN) && !lenq_empty;
  assign data_pop = rd_req && (reg_addr == REG_DATA) && (left_q != '0);
  assign irq_clr  = reg_req && reg_we && (reg_addr == REG_IRQ) && reg_wdata[0];

  assign add_words = pkt_done ? pkt_words  : '0;
  assign sub_words = claim    ? lenq_words : '0;

  always_comb begin
    occ_d  = occ_q + add_words - sub_words;
    left_d = left_q + sub_words - (data_pop ? CNT_W'(1) : CNT_W'(0));
    irq_d  = pkt_done || (irq_q && !irq_clr);
  end

  always_comb begin
    rdata_d = '0;
    case (reg_addr)
      REG_OCC:  rdata_d = 32'(occ_q);
      REG_LEN:  rdata_d = claim ? (32'(lenq_words) * BYTES_PER_WORD) : '0;
      REG_DEST: rdata_d = 32'(dest_q);
      REG_DATA: rdata_d = data_pop ? data_head : '0;
      REG_IRQ:  rdata_d = {31'd0, irq_q};
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q    <= '0;
      left_q   <= '0;
      dest_q   <= '0;
      irq_q    <= 1'b0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_req;
      irq_q    <= irq_d;
      if (pkt_done || claim) occ_q  <= occ_d;
      if (claim || data_pop) left_q <= left_d;
      if (claim)             dest_q <= lenq_dest;
      if (rd_req)            rdata_q <= rdata_d;
    end
  end

  assign reg_rdata  = rdata_q;
  assign reg_rvalid = rvalid_q;
  assign irq        = irq_q;

  assert_occ_matches_queue_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_q == '0) == lenq_empty);

  assert_claimed_words_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (left_q != '0) |-> !data_empty);

  assert_irq_on_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |=> irq);

  assert_empty_len_read_inert_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && reg_addr == REG_LEN && lenq_empty && !pkt_done) |=> $stable(occ_q));

  assert_read_answered_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> reg_rvalid);

endmodule

// File: rtl/pkt_rx_fifo.sv
module pkt_rx_fifo
  import pkt_rx_pkg::*;
#(
  parameter int DATA_DEPTH = 64,
  parameter int MAX_PKTS   = 8,
  parameter int DEST_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_tvalid,
  output logic              s_tready,
  input  logic [31:0]       s_tdata,
  input  logic              s_tlast,
  input  logic [DEST_W-1:0] s_tdest,
  input  logic              reg_req,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              reg_rvalid,
  output logic              irq
);

  localparam int CNT_W  = $clog2(DATA_DEPTH + 1);
  localparam int LENQ_W = DEST_W + CNT_W;

  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  logic              beat_acc, pkt_done, claim, data_pop;
  logic              data_full, data_empty, lenq_full, lenq_empty;
  logic [CNT_W-1:0]  pkt_words, lenq_words;
  logic [DEST_W-1:0] pkt_dest, lenq_dest;
  logic [31:0]       data_head;
  logic [LENQ_W-1:0] lenq_head;

  prf_ingress #(.DEST_W(DEST_W), .DEPTH(DATA_DEPTH), .CNT_W(CNT_W)) u_ingress (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .s_tvalid  (s_tvalid),
    .s_tlast   (s_tlast),
    .s_tdest   (s_tdest),
    .data_full (data_full),
    .lenq_full (lenq_full),
    .s_tready  (s_tready),
    .beat_acc  (beat_acc),
    .pkt_done  (pkt_done),
    .pkt_words (pkt_words),
    .pkt_dest  (pkt_dest)
  );

  prf_sync_fifo #(.W(WORD_W), .DEPTH(DATA_DEPTH)) u_word_store (
    .clk   (clk),
    .rst_n (rst_n_int),
    .push  (beat_acc),
    .din   (s_tdata),
    .pop   (data_pop),
    .head  (data_head),
    .full  (data_full),
    .empty (data_empty)
  );

  prf_sync_fifo #(.W(LENQ_W), .DEPTH(MAX_PKTS)) u_len_queue (
    .clk   (clk),
    .rst_n (rst_n_int),
    .push  (pkt_done),
    .din   ({pkt_dest, pkt_words}),
    .pop   (claim),
    .head  (lenq_head),
    .full  (lenq_full),
    .empty (lenq_empty)
  );

  assign lenq_words = lenq_head[CNT_W-1:0];
  assign lenq_dest  = lenq_head[LENQ_W-1:CNT_W];

  prf_regs #(.DEST_W(DEST_W), .CNT_W(CNT_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .reg_req    (reg_req),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .reg_rvalid (reg_rvalid),
    .irq        (irq),
    .pkt_done   (pkt_done),
    .pkt_words  (pkt_words),
    .lenq_empty (lenq_empty),
    .lenq_words (lenq_words),
    .lenq_dest  (lenq_dest),
    .claim      (claim),
    .data_empty (data_empty),
    .data_head  (data_head),
    .data_pop   (data_pop)
  );

endmodule

// File: tb/pkt_rx_fifo_bench.sv
module pkt_rx_fifo_bench;

  localparam int DEPTH = 16;
  localparam int PKTS  = 4;
  localparam int DW    = 4;

  logic          clk, rst_n;
  logic          s_tvalid, s_tready, s_tlast;
  logic [31:0]   s_tdata;
  logic [DW-1:0] s_tdest;
  logic          reg_req, reg_we, reg_rvalid, irq;
  logic [2:0]    reg_addr;
  logic [31:0]   reg_wdata, reg_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int exp_occ = 0;

  int          q_n[$];
  logic [3:0]  q_dest[$];
  logic [15:0] q_tag[$];

  pkt_rx_fifo #(.DATA_DEPTH(DEPTH), .MAX_PKTS(PKTS), .DEST_W(DW)) u_pkt_rx_fifo (
    .clk(clk), .rst_n(rst_n),
    .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tdata(s_tdata),
    .s_tlast(s_tlast), .s_tdest(s_tdest),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_req = 1'b1; reg_we = 1'b0; reg_addr = a;
    @(negedge clk);
    reg_req = 1'b0;
    check("R9 rvalid", 32'(reg_rvalid), 32'd1);
    v = reg_rdata;
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_req = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_req = 1'b0; reg_we = 1'b0;
  endtask

  // driver: push expected packet into the scoreboard
  task automatic expect_pkt(input int n, input logic [3:0] dest, input logic [15:0] tag);
    q_n.push_back(n); q_dest.push_back(dest); q_tag.push_back(tag);
  endtask

  task automatic send_beats(input int first, input int last_i, input int n,
                            input logic [3:0] dest, input logic [15:0] tag);
    for (int i = first; i <= last_i; i++) begin
      @(negedge clk);
      s_tvalid = 1'b1; s_tdata = {tag, 16'(i)}; s_tlast = (i == n - 1); s_tdest = dest;
      while (!s_tready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    s_tvalid = 1'b0; s_tlast = 1'b0;
    if (last_i == n - 1) exp_occ += n;
  endtask

  task automatic send_pkt(input int n, input logic [3:0] dest, input logic [15:0] tag);
    expect_pkt(n, dest, tag);
    send_beats(0, n - 1, n, dest, tag);
  endtask

  // monitor: drain one packet via the software sequence and compare with scoreboard
  task automatic drain_one();
    logic [31:0] v;
    int n; logic [3:0] d; logic [15:0] t;
    n = q_n.pop_front(); d = q_dest.pop_front(); t = q_tag.pop_front();
    reg_rd(3'd0, v); check("R1 occupancy before claim", v, 32'(exp_occ));
    reg_rd(3'd1, v); check("R2 byte length", v, 32'(n * 4));
    exp_occ -= n;
    reg_rd(3'd0, v); check("R3 occupancy after claim", v, 32'(exp_occ));
    reg_rd(3'd2, v); check("R4 destination", v, 32'(d));
    for (int i = 0; i < n; i++) begin
      reg_rd(3'd3, v); check("R5 data word", v, {t, 16'(i)});
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; s_tvalid = 1'b0; s_tlast = 1'b0; s_tdata = '0; s_tdest = '0;
    reg_req = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    check("R10 tready after reset", 32'(s_tready), 32'd1);
    check("R10 irq after reset", 32'(irq), 32'd0);
    reg_rd(3'd0, v); check("R1 occupancy after reset", v, 32'd0);

    // R6 empty length read
    reg_rd(3'd1, v); check("R6 empty length read", v, 32'd0);
    reg_rd(3'd0, v); check("R6 occupancy unchanged", v, 32'd0);
    reg_rd(3'd3, v); check("R5 data read with none claimed", v, 32'd0);

    // R1 partial packet not counted
    expect_pkt(3, 4'h5, 16'hA100);
    send_beats(0, 1, 3, 4'h5, 16'hA100);
    reg_rd(3'd0, v); check("R1 partial packet not counted", v, 32'd0);
    check("R8 irq low before last", 32'(irq), 32'd0);
    send_beats(2, 2, 3, 4'h5, 16'hA100);
    check("R8 irq after last", 32'(irq), 32'd1);

    // second packet back to back before any claim: R2/R3
    send_pkt(5, 4'h7, 16'hB200);
    reg_rd(3'd0, v); check("R1 two packets", v, 32'd8);
    drain_one();
    reg_rd(3'd0, v); check("R3 nonzero while second pending", 32'(v != 0), 32'd1);
    reg_rd(3'd3, v); check("R5 no read past claimed words", v, 32'd0);
    drain_one();
    reg_rd(3'd0, v); check("R3 zero after last claim", v, 32'd0);

    // R8 interrupt clear rules
    reg_rd(3'd4, v); check("R8 irq register read", v, 32'd1);
    reg_wr(3'd4, 32'h0000_0000);
    check("R8 write 0 keeps irq", 32'(irq), 32'd1);
    reg_wr(3'd4, 32'h0000_0001);
    check("R8 write 1 clears irq", 32'(irq), 32'd0);
    reg_rd(3'd4, v); check("R8 irq register after clear", v, 32'd0);

    // R9 unmapped address
    reg_rd(3'd6, v); check("R9 unmapped reads 0", v, 32'd0);

    // R7 length queue full
    for (int k = 0; k < PKTS; k++) send_pkt(1, 4'(k), 16'(16'hC000 + k));
    check("R7 tready low on full length queue", 32'(s_tready), 32'd0);
    drain_one();
    check("R7 tready back after claim", 32'(s_tready), 32'd1);
    for (int k = 1; k < PKTS; k++) drain_one();

    // R7 word store full
    send_pkt(DEPTH, 4'hE, 16'hD300);
    check("R7 tready low on full word store", 32'(s_tready), 32'd0);
    drain_one();
    check("R7 tready back after drain", 32'(s_tready), 32'd1);
    reg_rd(3'd1, v); check("R6 length read after drain", v, 32'd0);

    // R6: later packet still claimable after empty read
    send_pkt(2, 4'h3, 16'hE400);
    drain_one();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule